// File: doc/BRIEF.md
# Infrared Serial Pulse Shaper

This block sits between an asynchronous serial controller and an infrared transceiver. On transmit it watches the controller's serial output line. It frames each character as one start bit, eight data bits and one stop bit, with no parity. For every zero bit it emits a short high pulse on the infrared output. One bits leave that output low. Two pulse widths are available. The first lasts three sixteenths of a bit period and sits in the middle of the bit cell. The second lasts a fixed 1.6 µs, derived from the system clock frequency parameter. A single select input picks between them.

On receive, the infrared input is synchronised and its high level is timed. A pulse that lasts at least a programmable number of system clocks counts as a zero bit. The recovered serial line is then pulled low for one bit period, counted in 16x baud ticks from the pulse's leading edge. Pulses of either width are accepted, so the receiver does not depend on how the remote end shapes its pulses. The whole function works only while the shaping enable input is high. With it low, the infrared output stays low and the recovered line stays high.

Top module: `sir_shaper`

## Requirements
- R1: Within a character, each zero bit cell (the start bit and every zero data bit, data sent LSB first) carries exactly one pulse on `irTxOut`. One bits and the stop bit produce no pulse.
- R2: With `widthSel` = 0, each pulse is high for exactly 3 periods of `baudTick`, starting at the 6th tick into the bit cell, so it lies wholly inside the cell.
- R3: With `widthSel` = 1, each pulse is high for exactly ceil(CLK_FREQ_HZ × 1.6 µs) system clock cycles.
- R4: A pulse on `irRxIn` that stays high for at least `glitchLimit` clocks drives `rxSerial` low. When the transmit output is looped back, `rxSerial` sampled late in each bit cell reproduces the transmitted frame for both pulse widths.
- R5: A pulse on `irRxIn` that stays high for fewer than `glitchLimit` clocks leaves `rxSerial` high. A pulse of exactly `glitchLimit` clocks is accepted.
- R6: An accepted isolated pulse holds `rxSerial` low for one bit period measured from its leading edge. The low time is between 16 tick periods minus `glitchLimit` plus 3 clocks, and 16 tick periods.
- R7: While `shapeEn` is low, `irTxOut` stays low and `rxSerial` stays high, whatever arrives on `txSerial` or `irRxIn`.
- R8: During reset `irTxOut` is low and `rxSerial` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| shapeEn | input | 1 | Enables pulse shaping in both directions |
| widthSel | input | 1 | Transmit pulse width: 0 = 3/16 bit, 1 = fixed 1.6 µs |
| glitchLimit | input | GLITCH_W | Minimum accepted receive pulse length in clocks |
| baudTick | input | 1 | One-clock strobe at 16 times the baud rate |
| txSerial | input | 1 | Serial output of the UART transmitter, idle high |
| irTxOut | output | 1 | Infrared transmit pulse, active high |
| irRxIn | input | 1 | Infrared receive pulse, active high |
| rxSerial | output | 1 | Recovered serial line for the UART receiver, idle high |

## Verification
Characters are sent with data values spread across the full byte range, from all zeros to all ones, once in each width mode. The infrared output is looped back into the receiver, so every cell checks the pulse count and the pulse width for zeros and ones together with the recovered level. Isolated receive pulses of 1 to 8 clocks are swept against a glitch limit of 5. This separates rejected from accepted pulses at the exact boundary and measures the recovered low time. Repeating a pulse and a character with shaping disabled shows that neither path reacts.

// File: rtl/sir_pkg.sv
package sir_pkg;
  localparam int TICKS_PER_BIT = 16;
  localparam int PULSE_TICKS   = 3;
  localparam int FRAME_BITS    = 10;

  typedef struct packed {
    logic pulseStart;
    logic pulseStop;
    logic rxRestart;
    logic rxLow;
  } ctrl_strobe_t;

  typedef struct packed {
    logic rise;
    logic level;
    logic qualMet;
    logic bitDone;
  } rx_status_t;

  typedef enum logic [1:0] {RX_IDLE, RX_QUAL, RX_HOLD} rx_state_e;
endpackage

// File: rtl/sir_ctrl.sv
module sir_ctrl
  import sir_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         baudTick,
  input  logic         txSerial,
  input  rx_status_t   stat,
  output ctrl_strobe_t ctl
);
  localparam int PhaseW     = $clog2(TICKS_PER_BIT);
  localparam int BitW       = $clog2(FRAME_BITS);
  localparam int PulseFirst = (TICKS_PER_BIT - PULSE_TICKS) / 2;

  logic              txActive;
  logic [PhaseW-1:0] phase;
  logic [BitW-1:0]   bitIdx;
  rx_state_e         rxState;
  logic              keepLow;

  // transmit framing: phase counts ticks inside the current bit cell
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txActive <= 1'b0;
      phase    <= '0;
      bitIdx   <= '0;
    end else if (!enable) begin
      txActive <= 1'b0;
    end else if (!txActive) begin
      if (!txSerial) begin
        txActive <= 1'b1;
        phase    <= '0;
        bitIdx   <= '0;
      end
    end else if (baudTick) begin
      phase <= phase + 1'b1;
      if (phase == PhaseW'(TICKS_PER_BIT - 1)) begin
        if (bitIdx == BitW'(FRAME_BITS - 1)) txActive <= 1'b0;
        else bitIdx <= bitIdx + 1'b1;
      end
    end
  end

  assign ctl.pulseStart = enable && txActive && baudTick && !txSerial
                          && (phase == PhaseW'(PulseFirst - 1));
  assign ctl.pulseStop  = txActive && baudTick
                          && (phase == PhaseW'(PulseFirst + PULSE_TICKS - 1));

  // receive qualification and hold
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      keepLow <= 1'b0;
    end else if (!enable) begin
      rxState <= RX_IDLE;
      keepLow <= 1'b0;
    end else begin
      unique case (rxState)
        RX_IDLE: if (stat.rise) begin
          rxState <= stat.qualMet ? RX_HOLD : RX_QUAL;
          keepLow <= 1'b0;
        end
        RX_QUAL: begin
          if (!stat.level) rxState <= RX_IDLE;
          else if (stat.qualMet) rxState <= RX_HOLD;
        end
        RX_HOLD: begin
          if (stat.rise) begin
            if (!stat.qualMet) begin
              rxState <= RX_QUAL;
              keepLow <= 1'b1;
            end
          end else if (stat.bitDone) begin
            rxState <= RX_IDLE;
          end
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  assign ctl.rxRestart = enable && stat.rise;
  assign ctl.rxLow     = (rxState == RX_HOLD) || ((rxState == RX_QUAL) && keepLow);

  // R2: a pulse is only opened inside an active character frame
  assert_start_in_frame_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pulseStart |=> txActive);
  // R6: holding low always follows an accepted qualification or a hold
  assert_hold_entry_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == RX_HOLD) && $past(rxState) == RX_IDLE |-> $past(stat.rise));
endmodule

// File: rtl/sir_datapath.sv
module sir_datapath
  import sir_pkg::*;
#(
  parameter int FIXED_CYCLES = 77,
  parameter int GLITCH_W     = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic                widthSel,
  input  logic                baudTick,
  input  logic                irRxIn,
  input  logic [GLITCH_W-1:0] glitchLimit,
  input  ctrl_strobe_t        ctl,
  output rx_status_t          stat,
  output logic                irTx,
  output logic                rxSerial
);
  localparam int FixW  = $clog2(FIXED_CYCLES + 1);
  localparam int TickW = $clog2(TICKS_PER_BIT + 1);

  logic [FixW-1:0]     fixCnt;
  logic [1:0]          syncPipe;
  logic                syncPrev;
  logic                syncIn;
  logic [GLITCH_W-1:0] glitchCnt;
  logic [GLITCH_W:0]   runLen;
  logic [TickW-1:0]    rxTicks;

  // transmit pulse generator
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irTx   <= 1'b0;
      fixCnt <= '0;
    end else if (!enable) begin
      irTx   <= 1'b0;
      fixCnt <= '0;
    end else if (ctl.pulseStart) begin
      irTx   <= 1'b1;
      fixCnt <= FixW'(FIXED_CYCLES - 1);
    end else if (irTx) begin
      if (widthSel) begin
        if (fixCnt == '0) irTx <= 1'b0;
        else fixCnt <= fixCnt - 1'b1;
      end else if (ctl.pulseStop) begin
        irTx <= 1'b0;
      end
    end
  end

  // receive synchroniser and pulse length measurement
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncPipe  <= '0;
      syncPrev  <= 1'b0;
      glitchCnt <= '0;
    end else begin
      syncPipe <= {syncPipe[0], irRxIn};
      syncPrev <= syncPipe[1];
      if (stat.rise) glitchCnt <= GLITCH_W'(1);
      else if (syncIn && glitchCnt != '1) glitchCnt <= glitchCnt + 1'b1;
    end
  end

  assign syncIn       = syncPipe[1];
  assign runLen       = stat.rise ? (GLITCH_W+1)'(1) : {1'b0, glitchCnt} + 1'b1;
  assign stat.rise    = syncIn && !syncPrev;
  assign stat.level   = syncIn;
  assign stat.qualMet = syncIn && (runLen >= {1'b0, glitchLimit});

  // bit period timer for the recovered line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxTicks <= '0;
    else if (ctl.rxRestart) rxTicks <= '0;
    else if (baudTick && rxTicks != TickW'(TICKS_PER_BIT)) rxTicks <= rxTicks + 1'b1;
  end

  assign stat.bitDone = (rxTicks == TickW'(TICKS_PER_BIT));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxSerial <= 1'b1;
    else rxSerial <= !ctl.rxLow;
  end

  assert_pulse_from_start_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irTx) |-> $past(ctl.pulseStart));
  assert_fixed_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    irTx && widthSel |-> fixCnt < FixW'(FIXED_CYCLES));
  assert_low_needs_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxSerial) |-> $past(syncIn, 2));
  assert_off_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !irTx && rxSerial);
endmodule

// File: rtl/sir_shaper.sv
module sir_shaper
  import sir_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 48_000_000,
  parameter int GLITCH_W    = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                shapeEn,
  input  logic                widthSel,
  input  logic [GLITCH_W-1:0] glitchLimit,
  input  logic                baudTick,
  input  logic                txSerial,
  output logic                irTxOut,
  input  logic                irRxIn,
  output logic                rxSerial
);
  // 1.6 us in clocks, rounded up: ceil(f * 16 / 10^7)
  localparam longint FixedNum    = longint'(CLK_FREQ_HZ) * 64'sd16;
  localparam int     FixedRaw    = int'((FixedNum + 64'sd9_999_999) / 64'sd10_000_000);
  localparam int     FixedCycles = (FixedRaw < 1) ? 1 : FixedRaw;

  ctrl_strobe_t ctl;
  rx_status_t   stat;

  sir_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (shapeEn),
    .baudTick (baudTick),
    .txSerial (txSerial),
    .stat     (stat),
    .ctl      (ctl)
  );

  sir_datapath #(
    .FIXED_CYCLES (FixedCycles),
    .GLITCH_W     (GLITCH_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (shapeEn),
    .widthSel    (widthSel),
    .baudTick    (baudTick),
    .irRxIn      (irRxIn),
    .glitchLimit (glitchLimit),
    .ctl         (ctl),
    .stat        (stat),
    .irTx        (irTxOut),
    .rxSerial    (rxSerial)
  );
endmodule

// File: tb/sir_shaper_test.sv
module sir_shaper_test;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 12_345_678;
  localparam int TD         = 3;
  localparam int CELL       = 16 * TD;
  localparam int GW         = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic shapeEn = 1'b0;
  logic widthSel = 1'b0;
  logic [GW-1:0] glitchLimit = 8'd2;
  logic baudTick = 1'b0;
  logic txSerial = 1'b1;
  logic irTxOut;
  logic irRxIn;
  logic rxSerial;
  logic loopback = 1'b0;
  logic rxDrive = 1'b0;
  int   divCnt = 0;
  int   checks = 0;
  int   errors = 0;
  int   fixedExp;

  assign irRxIn = loopback ? irTxOut : rxDrive;

  sir_shaper #(.CLK_FREQ_HZ(CLK_HZ), .GLITCH_W(GW)) uut (
    .clk(clk), .rstN(rstN), .shapeEn(shapeEn), .widthSel(widthSel),
    .glitchLimit(glitchLimit), .baudTick(baudTick), .txSerial(txSerial),
    .irTxOut(irTxOut), .irRxIn(irRxIn), .rxSerial(rxSerial));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    divCnt   <= (divCnt == TD-1) ? 0 : divCnt + 1;
    baudTick <= (divCnt == TD-1);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // sends one character; per cell counts pulse clocks and samples the recovered line
  task automatic sendByte(input logic [7:0] b, input bit wmode);
    widthSel = wmode;
    for (int c = 0; c < 10; c++) begin
      logic bv;
      int highs;
      logic rxs;
      bv = (c == 0) ? 1'b0 : (c == 9) ? 1'b1 : b[c-1];
      txSerial = bv;
      highs = 0;
      rxs = 1'b1;
      for (int k = 1; k <= CELL; k++) begin
        @(negedge clk);
        if (irTxOut) highs++;
        if (k == 40) rxs = rxSerial;
      end
      if (!shapeEn)
        check(highs == 0, "R7 tx idle when disabled", highs, 0);
      else if (bv)
        check(highs == 0, "R1 no pulse on one bit", highs, 0);
      else if (wmode)
        check(highs == fixedExp, "R3 fixed width pulse", highs, fixedExp);
      else
        check(highs == 3*TD, "R2 3/16 width pulse", highs, 3*TD);
      if (shapeEn && loopback)
        check(rxs == bv, "R4 loopback recovered bit", int'(rxs), int'(bv));
    end
    txSerial = 1'b1;
    repeat (2*CELL) @(negedge clk);
  endtask

  // isolated receive pulse of len clocks; returns clocks of low recovered line
  task automatic pulseRx(input int len, output int lowCnt);
    lowCnt = 0;
    rxDrive = 1'b1;
    for (int k = 1; k <= 100; k++) begin
      @(negedge clk);
      if (k == len) rxDrive = 1'b0;
      if (!rxSerial) lowCnt++;
    end
  endtask

  initial begin
    repeat (190_000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lowCnt;
    fixedExp = int'($ceil(real'(CLK_HZ) * 1.6e-6));
    repeat (4) @(negedge clk);
    check(irTxOut == 1'b0, "R8 reset irTxOut", int'(irTxOut), 0);
    check(rxSerial == 1'b1, "R8 reset rxSerial", int'(rxSerial), 1);
    rstN = 1'b1;
    shapeEn = 1'b1;
    repeat (2*CELL) @(negedge clk);

    // R1 R2 R4: 3/16 pulses, looped back
    loopback = 1'b1;
    glitchLimit = 8'd2;
    for (int i = 0; i < 64; i++) sendByte(8'(i*4), 1'b0);
    // R3 R4: fixed width pulses, looped back
    for (int i = 0; i < 64; i++) sendByte(8'(i*4+3), 1'b1);

    // R5 R6: glitch threshold sweep
    loopback = 1'b0;
    glitchLimit = 8'd5;
    repeat (CELL) @(negedge clk);
    for (int len = 1; len <= 8; len++) begin
      pulseRx(len, lowCnt);
      if (len < 5)
        check(lowCnt == 0, "R5 short pulse ignored", lowCnt, 0);
      else
        check(lowCnt >= CELL - 5 - 3 && lowCnt <= CELL, "R6 hold length", lowCnt, CELL);
    end

    // R7: disabled paths
    shapeEn = 1'b0;
    repeat (4) @(negedge clk);
    pulseRx(8, lowCnt);
    check(lowCnt == 0, "R7 rx idle when disabled", lowCnt, 0);
    sendByte(8'h00, 1'b0);
    sendByte(8'h5A, 1'b1);
    shapeEn = 1'b1;

    // back on: a plain pulse is recovered again
    repeat (CELL) @(negedge clk);
    pulseRx(6, lowCnt);
    check(lowCnt >= CELL - 8 && lowCnt <= CELL, "R6 hold after re-enable", lowCnt, CELL);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule